// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block holds the sharer record for a single coherent memory block at its home node. Instead of one presence bit per node, it keeps a handful of node-ID pointer slots. Commands arrive on a plain command port, one at a time:

- add a sharer;
- drop a node from the record;
- a write by a given node.

A write walks the record and streams out, one node ID per transfer, every node that must be invalidated. After the walk the record holds only the writer.

When a new sharer arrives and every slot is already taken, the entry falls back to an overflow representation. A build-time parameter picks that representation:

- a broadcast flag, so the next write invalidates everyone;
- evicting one existing pointer, round-robin, and streaming the evicted node out for invalidation at once;
- a coarse vector with one bit per group of nodes.

The invalidation stream is valid/ready:

- `inv_node` is only meaningful while `inv_valid` is high.
- Once raised, `inv_valid` and `inv_node` hold until `inv_ready` is sampled high at a clock edge.
- The consumer may hold `inv_ready` low for any number of cycles.
- While the stream is busy, `cmd_ready` stays low, so commands are back-pressured rather than lost.

Top module: `lp_dir_entry`

## Requirements
- R1: After reset the entry records no sharers, `cmd_ready` is 1 and `inv_valid` is 0, so an immediate write emits no node.
- R2: A command is taken when `cmd_valid` and `cmd_ready` are both 1. `cmd_op` 0 adds `cmd_node` as a sharer, and adding a node already held in a slot occupies no further slot.
- R3: In pointer form, a write (`cmd_op` 2) emits exactly the recorded sharers other than the writer, each node exactly once, in any order.
- R4: The writing node never appears in the invalidation stream of its own write, in any overflow form.
- R5: When a write's stream finishes, the entry holds only the writer in pointer form, with the broadcast and coarse states cleared. A second write by another node therefore emits just the first writer.
- R6: With the broadcast option (OVF=0), adding a new sharer while all slots are full sets the broadcast state. The next write then emits every node from 0 to NODES-1 except the writer.
- R7: With the evict option (OVF=1), adding a new sharer while all slots are full overwrites the slot named by a round-robin pointer, which starts at slot 0 and advances by one per eviction. Before `cmd_ready` returns, exactly one node is emitted: the displaced node. Added sharers go into the lowest-numbered free slot.
- R8: With the coarse option (OVF=2), an overflowing add sets one bit per group index `node / GROUP`, covering every recorded pointer and the new node. Later adds set their node's group bit. A write emits every node of every set group except the writer.
- R9: `cmd_op` 1 clears the slot holding `cmd_node` while in pointer form. Once broadcast or coarse form is active, it has no effect on what the next write emits. A drop never emits anything.
- R10: While `inv_valid` is 1 and `inv_ready` is 0, `inv_valid` and `inv_node` hold at the next cycle. `cmd_ready` is 0 while `inv_valid` is 1, and is 0 in the cycle after a write is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Entry idle and able to take a command |
| cmd_op | input | 2 | 0 add sharer, 1 drop node, 2 write |
| cmd_node | input | $clog2(NODES) | Node the command refers to |
| inv_valid | output | 1 | Invalidation target present |
| inv_ready | input | 1 | Consumer takes the target this cycle |
| inv_node | output | $clog2(NODES) | Node to invalidate |

## Verification
The checker assumes the consumer drives `inv_ready` freely. It also assumes that a command offered while `cmd_ready` is low is simply not taken, so the writer it remembers is the one from the last accepted command. The stimulus issues commands only after the entry has drained back to idle, and throttles `inv_ready` with a fixed stall pattern. Every stream therefore exercises the hold rule, while the remembered writer always matches the write in flight. Sweeps cover every writer node against sharer lists of zero to seven nodes, with repeated adds and drops, in all three overflow options.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  typedef enum logic [1:0] {
    CMD_ADD   = 2'd0,
    CMD_DROP  = 2'd1,
    CMD_WRITE = 2'd2
  } lpd_cmd_e;

  typedef enum logic [1:0] {
    OVF_BCAST  = 2'd0,
    OVF_EVICT  = 2'd1,
    OVF_COARSE = 2'd2
  } lpd_ovf_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_EVICT = 2'd2
  } lpd_state_e;
endpackage

// File: rtl/lpd_slots.sv
// Pointer slot array: storage, lookup of a probe node, lowest free slot.
module lpd_slots #(
  parameter int SLOTS = 4,
  parameter int NW    = 4,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NW-1:0]             probe_id,
  output logic                      hit,
  output logic                      full,
  output logic [SW-1:0]             free_idx,
  input  logic                      ins_en,
  input  logic [SW-1:0]             ins_idx,
  input  logic [NW-1:0]             ins_id,
  input  logic                      drop_en,
  input  logic                      solo_en,
  input  logic [NW-1:0]             solo_id,
  output logic [SLOTS-1:0]          vld,
  output logic [SLOTS-1:0][NW-1:0]  ids
);
  logic [SLOTS-1:0]         vld_q;
  logic [SLOTS-1:0][NW-1:0] ids_q;
  logic [SLOTS-1:0]         match;

  for (genvar g = 0; g < SLOTS; g++) begin : g_match
    assign match[g] = vld_q[g] && (ids_q[g] == probe_id);
  end

  assign hit  = |match;
  assign full = &vld_q;
  assign vld  = vld_q;
  assign ids  = ids_q;

  always_comb begin
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = SW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ids_q <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (solo_en) begin
          vld_q[i] <= (i == 0);
          if (i == 0) ids_q[i] <= solo_id;
        end else if (ins_en && (ins_idx == SW'(i))) begin
          vld_q[i] <= 1'b1;
          ids_q[i] <= ins_id;
        end else if (drop_en && match[i]) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lpd_walker.sv
// Index walker for the invalidation stream: skips non-members in one
// cycle each, waits on the consumer for members.
module lpd_walker #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic          member,
  input  logic          ready,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] idx,
  output logic          emit,
  output logic          done
);
  logic step;
  logic last;

  assign step = !member || ready;
  assign last = (idx == limit - CW'(1));
  assign emit = run && member;
  assign done = run && step && last;

  always_ff @(posedge clk) begin
    if (!rst_n)                 idx <= '0;
    else if (start)             idx <= '0;
    else if (run && step && !last) idx <= idx + CW'(1);
  end
endmodule

// File: rtl/lp_dir_entry.sv
module lp_dir_entry
  import lpd_pkg::*;
#(
  parameter int       NODES = 16,
  parameter int       SLOTS = 4,
  parameter int       GROUP = 4,
  parameter lpd_ovf_e OVF   = OVF_BCAST,
  localparam int      NW    = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [NW-1:0] cmd_node,
  output logic          inv_valid,
  input  logic          inv_ready,
  output logic [NW-1:0] inv_node
);
  localparam int NGRP = (NODES + GROUP - 1) / GROUP;
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int SPAN = (NODES > SLOTS) ? NODES : SLOTS;
  localparam int CW   = $clog2(SPAN + 1);

  function automatic logic [GW-1:0] grp_of(input logic [NW-1:0] n);
    return GW'(int'(n) / GROUP);
  endfunction

  lpd_state_e          state_q;
  logic                bcast_q, coarse_q;
  logic [NGRP-1:0]     cvec_q;
  logic [SW-1:0]       rr_q;
  logic [NW-1:0]       writer_q, victim_q;

  logic                accept, is_add, is_drop, is_write, ptr_mode, overflow;
  logic                hit, full;
  logic [SW-1:0]       free_idx;
  logic [SLOTS-1:0]    vld;
  logic [SLOTS-1:0][NW-1:0] ids;
  logic [NGRP-1:0]     slot_grps;
  logic [CW-1:0]       walk_idx, walk_limit;
  logic                walk_emit, walk_done, member;
  logic [NW-1:0]       cand;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign is_add    = (cmd_op == CMD_ADD);
  assign is_drop   = (cmd_op == CMD_DROP);
  assign is_write  = (cmd_op == CMD_WRITE);
  assign ptr_mode  = !bcast_q && !coarse_q;
  assign overflow  = accept && is_add && ptr_mode && !hit && full;

  lpd_slots #(.SLOTS(SLOTS), .NW(NW)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .probe_id (cmd_node),
    .hit      (hit),
    .full     (full),
    .free_idx (free_idx),
    .ins_en   (accept && is_add && ptr_mode && !hit &&
               (!full || (OVF == OVF_EVICT))),
    .ins_idx  (full ? rr_q : free_idx),
    .ins_id   (cmd_node),
    .drop_en  (accept && is_drop && ptr_mode),
    .solo_en  (walk_done),
    .solo_id  (writer_q),
    .vld      (vld),
    .ids      (ids)
  );

  // Group bits covered by the pointers, used when switching to coarse form.
  always_comb begin
    slot_grps = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i]) slot_grps[grp_of(ids[i])] = 1'b1;
    end
  end

  // Candidate for the current walk index: a slot in pointer form,
  // a node number in broadcast or coarse form.
  always_comb begin
    cand   = walk_idx[NW-1:0];
    member = 1'b0;
    if (ptr_mode) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (walk_idx == CW'(i)) begin
          cand   = ids[i];
          member = vld[i];
        end
      end
    end else begin
      member = bcast_q || cvec_q[grp_of(cand)];
    end
    member = member && (cand != writer_q);
  end

  assign walk_limit = ptr_mode ? CW'(SLOTS) : CW'(NODES);

  lpd_walker #(.CW(CW)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept && is_write),
    .run    (state_q == ST_WALK),
    .member (member),
    .ready  (inv_ready),
    .limit  (walk_limit),
    .idx    (walk_idx),
    .emit   (walk_emit),
    .done   (walk_done)
  );

  assign inv_valid = walk_emit || (state_q == ST_EVICT);
  assign inv_node  = (state_q == ST_EVICT) ? victim_q : cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bcast_q  <= 1'b0;
      coarse_q <= 1'b0;
      cvec_q   <= '0;
      rr_q     <= '0;
      writer_q <= '0;
      victim_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept && is_write) begin
            writer_q <= cmd_node;
            state_q  <= ST_WALK;
          end else if (accept && is_add && coarse_q) begin
            cvec_q[grp_of(cmd_node)] <= 1'b1;
          end else if (overflow) begin
            if (OVF == OVF_BCAST) begin
              bcast_q <= 1'b1;
            end else if (OVF == OVF_COARSE) begin
              coarse_q <= 1'b1;
              cvec_q   <= slot_grps | (NGRP'(1) << grp_of(cmd_node));
            end else begin
              victim_q <= ids[rr_q];
              rr_q     <= (rr_q == SW'(SLOTS - 1)) ? '0 : rr_q + SW'(1);
              state_q  <= ST_EVICT;
            end
          end
        end
        ST_WALK: begin
          if (walk_done) begin
            state_q  <= ST_IDLE;
            bcast_q  <= 1'b0;
            coarse_q <= 1'b0;
            cvec_q   <= '0;
          end
        end
        ST_EVICT: begin
          if (inv_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lp_dir_entry_chk.sv
module lp_dir_entry_chk #(
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [NW-1:0] cmd_node,
  input logic          inv_valid,
  input logic          inv_ready,
  input logic [NW-1:0] inv_node
);
  logic          wr_last;
  logic [NW-1:0] wr_node;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_last <= 1'b0;
      wr_node <= '0;
    end else if (cmd_valid && cmd_ready) begin
      wr_last <= (cmd_op == 2'd2);
      wr_node <= cmd_node;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cmd_ready && !inv_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_node));

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !cmd_ready);

  a_r10_write_walks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'd2 |=> !cmd_ready);

  a_r4_no_self: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && wr_last |-> inv_node != wr_node);
endmodule

bind lp_dir_entry lp_dir_entry_chk #(.NW(NW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_node  (cmd_node),
  .inv_valid (inv_valid),
  .inv_ready (inv_ready),
  .inv_node  (inv_node)
);

// File: tb/lp_dir_entry_test.sv
module lp_dir_entry_test;
  import lpd_pkg::*;
  localparam int CLK_NS = 10;
  localparam int NODES  = 16;
  localparam int SLOTS  = 4;
  localparam int GROUP  = 4;
  localparam int NW     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic          cv[3];
  logic [1:0]    cop[3];
  logic [NW-1:0] cnode[3];
  logic          crdy[3];
  logic          iv[3];
  logic          ir[3];
  logic [NW-1:0] inode[3];

  for (genvar m = 0; m < 3; m++) begin : g_mode
    lp_dir_entry #(.NODES(NODES), .SLOTS(SLOTS), .GROUP(GROUP),
                   .OVF(lpd_ovf_e'(m))) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cv[m]), .cmd_ready(crdy[m]),
      .cmd_op(cop[m]), .cmd_node(cnode[m]), .inv_valid(iv[m]),
      .inv_ready(ir[m]), .inv_node(inode[m]));
  end

  int checks = 0;
  int failures = 0;
  int stall = 0;
  bit done_flag = 0;

  // Reference state per overflow option
  bit              mv[3][SLOTS];
  int              mid[3][SLOTS];
  int              mrr[3];
  bit              mbc[3], mco[3];
  logic [3:0]      mcv[3];

  task automatic check(input bit ok, input string tag,
                       input logic [NODES-1:0] got, input logic [NODES-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model_cmd(input int m, input int op, input int n,
                           output logic [NODES-1:0] exp, output string tag);
    bit hitm; int fr;
    exp = '0;
    if (op == 0) begin
      tag = "R2";
      hitm = 0; fr = -1;
      for (int i = SLOTS - 1; i >= 0; i--) begin
        if (mv[m][i] && mid[m][i] == n) hitm = 1;
        if (!mv[m][i]) fr = i;
      end
      if (mco[m]) begin
        mcv[m][n / GROUP] = 1'b1;
        tag = "R8";
      end else if (mbc[m] || hitm) begin
      end else if (fr >= 0) begin
        mv[m][fr] = 1; mid[m][fr] = n;
      end else if (m == 0) begin
        mbc[m] = 1; tag = "R6";
      end else if (m == 2) begin
        mco[m] = 1; mcv[m] = '0;
        for (int i = 0; i < SLOTS; i++) mcv[m][mid[m][i] / GROUP] = 1'b1;
        mcv[m][n / GROUP] = 1'b1;
        tag = "R8";
      end else begin
        exp[mid[m][mrr[m]]] = 1'b1;
        mid[m][mrr[m]] = n;
        mrr[m] = (mrr[m] + 1) % SLOTS;
        tag = "R7";
      end
    end else if (op == 1) begin
      tag = "R9";
      if (!mbc[m] && !mco[m])
        for (int i = 0; i < SLOTS; i++)
          if (mv[m][i] && mid[m][i] == n) mv[m][i] = 0;
    end else begin
      if (mbc[m]) begin
        tag = "R6"; exp = '1;
      end else if (mco[m]) begin
        tag = "R8";
        for (int j = 0; j < NODES; j++) exp[j] = mcv[m][j / GROUP];
      end else begin
        tag = "R3";
        for (int i = 0; i < SLOTS; i++) if (mv[m][i]) exp[mid[m][i]] = 1'b1;
      end
      exp[n] = 1'b0;
      for (int i = 0; i < SLOTS; i++) mv[m][i] = (i == 0);
      mid[m][0] = n;
      mbc[m] = 0; mco[m] = 0; mcv[m] = '0;
    end
  endtask

  task automatic run_cmd(input int m, input int op, input int n, input string force_tag);
    logic [NODES-1:0] exp, got;
    string tag;
    bit pend; logic [NW-1:0] held; int guard;
    model_cmd(m, op, n, exp, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    cv[m] = 1'b1; cop[m] = 2'(op); cnode[m] = NW'(n);
    #1;
    check(crdy[m] == 1'b1, "R10 ready before command", {15'd0, crdy[m]}, 16'd1);
    @(negedge clk);
    cv[m] = 1'b0;
    got = '0; pend = 0; held = '0; guard = 0;
    forever begin
      ir[m] = ((stall % 3) != 1);
      stall++;
      #1;
      if (crdy[m]) begin
        if (iv[m]) check(0, "R10 ready while streaming", 16'd1, 16'd0);
        break;
      end
      if (iv[m]) begin
        if (pend && inode[m] != held)
          check(0, "R10 node changed under stall", 16'(inode[m]), 16'(held));
        if (ir[m]) begin
          if (got[inode[m]]) check(0, "R3 duplicate node", got, exp);
          got[inode[m]] = 1'b1;
          pend = 0;
        end else begin
          pend = 1; held = inode[m];
        end
      end else if (pend) begin
        check(0, "R10 valid dropped under stall", 16'd0, 16'd1);
        pend = 0;
      end
      guard++;
      if (guard > 200) begin
        check(0, "R10 stream never ended", got, exp);
        break;
      end
      @(negedge clk);
    end
    ir[m] = 1'b0;
    check(got == exp, tag, got, exp);
    if (op == 2) check(!got[n], "R4 writer excluded", got, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin
      cv[m] = 0; cop[m] = '0; cnode[m] = '0; ir[m] = 0;
      mrr[m] = 0; mbc[m] = 0; mco[m] = 0; mcv[m] = '0;
      for (int i = 0; i < SLOTS; i++) begin mv[m][i] = 0; mid[m][i] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 3; m++)
      check(crdy[m] && !iv[m], "R1 idle after reset",
            {14'd0, crdy[m], iv[m]}, 16'd2);
    for (int m = 0; m < 3; m++) run_cmd(m, 2, 5, "R1");

    for (int m = 0; m < 3; m++) begin
      for (int w = 0; w < NODES; w++) begin
        for (int ns = 0; ns < 8; ns++) begin
          int prev, n0;
          prev = 0; n0 = 0;
          for (int i = 0; i < ns; i++) begin
            int n;
            n = (w * 7 + i * 5 + ns) % NODES;
            if (i % 4 == 3) n = prev;
            if (i == 0) n0 = n;
            run_cmd(m, 0, n, "");
            prev = n;
          end
          if (ns % 2 == 1) run_cmd(m, 1, n0, "");
          run_cmd(m, 2, w, "");
          run_cmd(m, 2, (w + 1) % NODES, "R5");
        end
      end
    end
    done_flag = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule